// File: doc/BRIEF.md
# Detector acquisition timing sequencer

This block times one acquisition cycle of a pixel detector front end. A one-cycle strobe on either of two trigger inputs starts the cycle. One input is a run trigger and the other is an event strobe. The sequencer then moves through a fixed chain of phases:

1. A programmable pre-start delay.
2. An acquisition delay counted in ticks of a divide-by-128 prescaler.
3. The integration window, during which the amplifier reset is released.
4. A settle period with the sample-and-hold switch open.
5. A full single-slope ramp, during which the conversion counter is enabled.

Every programmed setting N means N+1 units. All counts are in cycles of the 125 MHz system clock, except the acquisition delay, whose unit is 128 cycles.

The configuration is captured when a trigger is accepted. Changes to the configuration inputs during a cycle therefore do not affect that cycle. A trigger that arrives while a cycle is running is dropped, and a sticky flag records the miss. The ramp always runs every programmed step, so that saturated pixels also see their comparators fire. A cycle timer measures the number of clocks from the first delay cycle to the closing done cycle and holds the result on an output. A one-cycle done pulse marks the return to idle.

Top module: `acq_timing_seq`

## Requirements
- R1: While reset is held and right after it, all strobes are low, busy, done and missed_trig are 0, and cycle_len is 0.
- R2: From idle, a high level on trig_run or on trig_evt at a rising edge starts a cycle. Busy stays high and amp_rst_release stays low for (cfg_trig_dly+1) + 128*(cfg_acq_dly+1) cycles, and then the window opens.
- R3: The acquisition delay is counted in units of exactly 128 clocks. Each increment of cfg_acq_dly moves the window opening 128 cycles later.
- R4: amp_rst_release stays high for exactly cfg_int_time+1 consecutive cycles.
- R5: When the window closes, sh_hold rises and cnt_en stays low for cfg_dig_dly+1 cycles.
- R6: cnt_en stays high for (cfg_step_cnt+1)*(cfg_step_per+1) cycles. ramp_step pulses cfg_step_cnt+1 times, once at the start of every step period, and the first pulse falls on the first cnt_en cycle.
- R7: One cycle after the ramp ends, done is high for exactly one cycle, and busy is low in the cycle after that.
- R8: After done, cycle_len holds the total count of busy cycles of that cycle, DONE cycle included. This count equals (T+1)+128(A+1)+(I+1)+(D+1)+(C+1)(P+1)+1.
- R9: A trigger on either input during a busy cycle is ignored and sets missed_trig. The next accepted trigger clears missed_trig.
- R10: Configuration inputs that change during a busy cycle have no effect on the phase lengths of that cycle.
- R11: The 14-bit step count at its maximum of 0x3FFF runs a complete ramp of 16384 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_run | input | 1 | Run trigger strobe |
| trig_evt | input | 1 | Event strobe trigger |
| cfg_trig_dly | input | TRIG_W | Pre-start delay, value+1 clocks |
| cfg_acq_dly | input | ACQ_W | Acquisition delay, value+1 prescaler ticks |
| cfg_int_time | input | INT_W | Integration window, value+1 clocks |
| cfg_dig_dly | input | DIG_W | Sample-and-hold settle, value+1 clocks |
| cfg_step_cnt | input | STEP_CNT_W | Ramp steps minus one |
| cfg_step_per | input | STEP_PER_W | Clocks per ramp step minus one |
| amp_rst_release | output | 1 | High while the amplifier reset is released (window) |
| sh_hold | output | 1 | High while the sample-and-hold switch is open (settle and ramp) |
| ramp_step | output | 1 | One-cycle pulse that advances the ramp |
| cnt_en | output | 1 | Conversion counter enable for the full ramp |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle pulse ending a cycle |
| missed_trig | output | 1 | Sticky flag for a trigger dropped while busy |
| cycle_len | output | TIMER_W | Clock count of the last completed cycle |

## Verification
The assertions assume that the configuration inputs are held steady during the cycle in which a trigger is accepted, and that reset is applied before the first trigger. The bench changes the configuration only one clock after the accepting edge. It applies triggers only on whole clock cycles, driving them just after a rising edge. Random settings are kept small, so that each cycle finishes in a few hundred clocks. The maximum step count and the all-zero settings are applied as directed cases.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TRIG_DLY, PH_ACQ_DLY, PH_INTEGRATE, PH_SETTLE, PH_RAMP, PH_DONE
  } acq_phase_t;

  // Total clocks of one cycle, including the closing done cycle.
  function automatic longint unsigned acq_cycle_clocks(
    input longint unsigned t, input longint unsigned a,
    input longint unsigned i, input longint unsigned d,
    input longint unsigned c, input longint unsigned p,
    input longint unsigned div);
    return (t + 1) + (a + 1) * div + (i + 1) + (d + 1) + (c + 1) * (p + 1) + 1;
  endfunction

endpackage

// File: rtl/acq_prescaler.sv
module acq_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)          cnt <= '0;
    else if (cnt == W'(DIV - 1)) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == W'(DIV - 1));

  generate
    if (DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/acq_ramp.sv
module acq_ramp #(
  parameter int CNT_W = 14,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] step_max,
  input  logic [PER_W-1:0] period,
  output logic             step,
  output logic             last
);
  logic [PER_W-1:0] per_cnt;
  logic [CNT_W-1:0] idx;
  logic             per_end;

  assign per_end = (per_cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      per_cnt <= '0;
      idx     <= '0;
    end else if (per_end) begin
      per_cnt <= '0;
      idx     <= idx + 1'b1;
    end else begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  assign step = en && (per_cnt == '0);
  assign last = en && per_end && (idx == step_max);

  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (idx <= step_max));
  // R11
  ramp_no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last) |=> en);
endmodule

// File: rtl/acq_cycle_timer.sv
module acq_cycle_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic         fin,
  output logic [W-1:0] len
);
  logic [W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      len     <= '0;
    end else begin
      if (start)    run_cnt <= '0;
      else if (run) run_cnt <= run_cnt + 1'b1;
      if (fin)      len <= run_cnt + 1'b1;
    end
  end

  // R8
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(len));
endmodule

// File: rtl/acq_timing_seq.sv
module acq_timing_seq
  import acq_seq_pkg::*;
#(
  parameter int TRIG_W     = 16,
  parameter int ACQ_W      = 10,
  parameter int INT_W      = 16,
  parameter int DIG_W      = 12,
  parameter int STEP_CNT_W = 14,
  parameter int STEP_PER_W = 8,
  parameter int ACQ_DIV    = 128,
  parameter int TIMER_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_run,
  input  logic                  trig_evt,
  input  logic [TRIG_W-1:0]     cfg_trig_dly,
  input  logic [ACQ_W-1:0]      cfg_acq_dly,
  input  logic [INT_W-1:0]      cfg_int_time,
  input  logic [DIG_W-1:0]      cfg_dig_dly,
  input  logic [STEP_CNT_W-1:0] cfg_step_cnt,
  input  logic [STEP_PER_W-1:0] cfg_step_per,
  output logic                  amp_rst_release,
  output logic                  sh_hold,
  output logic                  ramp_step,
  output logic                  cnt_en,
  output logic                  busy,
  output logic                  done,
  output logic                  missed_trig,
  output logic [TIMER_W-1:0]    cycle_len
);
  localparam int CW_A = (TRIG_W > ACQ_W) ? TRIG_W : ACQ_W;
  localparam int CW_B = (INT_W > DIG_W) ? INT_W : DIG_W;
  localparam int CW   = (CW_A > CW_B) ? CW_A : CW_B;

  acq_phase_t state, nxt;
  logic [CW-1:0] ph_cnt;
  logic          ph_zero, trig_any, accept, acq_tick, ramp_last;

  logic [TRIG_W-1:0]     lat_trig;
  logic [ACQ_W-1:0]      lat_acq;
  logic [INT_W-1:0]      lat_int;
  logic [DIG_W-1:0]      lat_dig;
  logic [STEP_CNT_W-1:0] lat_cnt;
  logic [STEP_PER_W-1:0] lat_per;

  assign trig_any = trig_run | trig_evt;
  assign accept   = (state == PH_IDLE) && trig_any;
  assign ph_zero  = (ph_cnt == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      PH_IDLE:      if (trig_any)            nxt = PH_TRIG_DLY;
      PH_TRIG_DLY:  if (ph_zero)             nxt = PH_ACQ_DLY;
      PH_ACQ_DLY:   if (acq_tick && ph_zero) nxt = PH_INTEGRATE;
      PH_INTEGRATE: if (ph_zero)             nxt = PH_SETTLE;
      PH_SETTLE:    if (ph_zero)             nxt = PH_RAMP;
      PH_RAMP:      if (ramp_last)           nxt = PH_DONE;
      PH_DONE:                               nxt = PH_IDLE;
      default:                               nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= PH_IDLE;
      ph_cnt      <= '0;
      missed_trig <= 1'b0;
      lat_trig    <= '0;
      lat_acq     <= '0;
      lat_int     <= '0;
      lat_dig     <= '0;
      lat_cnt     <= '0;
      lat_per     <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        lat_trig    <= cfg_trig_dly;
        lat_acq     <= cfg_acq_dly;
        lat_int     <= cfg_int_time;
        lat_dig     <= cfg_dig_dly;
        lat_cnt     <= cfg_step_cnt;
        lat_per     <= cfg_step_per;
        missed_trig <= 1'b0;
      end else if (state != PH_IDLE && trig_any) begin
        missed_trig <= 1'b1;
      end
      if (nxt != state) begin
        unique case (nxt)
          PH_TRIG_DLY:  ph_cnt <= CW'(cfg_trig_dly);
          PH_ACQ_DLY:   ph_cnt <= CW'(lat_acq);
          PH_INTEGRATE: ph_cnt <= CW'(lat_int);
          PH_SETTLE:    ph_cnt <= CW'(lat_dig);
          default:      ph_cnt <= '0;
        endcase
      end else if (state == PH_TRIG_DLY || state == PH_INTEGRATE ||
                   state == PH_SETTLE || (state == PH_ACQ_DLY && acq_tick)) begin
        ph_cnt <= ph_cnt - 1'b1;
      end
    end
  end

  acq_prescaler #(.DIV(ACQ_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(state == PH_ACQ_DLY), .tick(acq_tick));

  acq_ramp #(.CNT_W(STEP_CNT_W), .PER_W(STEP_PER_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(state == PH_RAMP),
    .step_max(lat_cnt), .period(lat_per), .step(ramp_step), .last(ramp_last));

  acq_cycle_timer #(.W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .run(state != PH_IDLE), .fin(state == PH_DONE), .len(cycle_len));

  assign amp_rst_release = (state == PH_INTEGRATE);
  assign sh_hold         = (state == PH_SETTLE) || (state == PH_RAMP);
  assign cnt_en          = (state == PH_RAMP);
  assign busy            = (state != PH_IDLE);
  assign done            = (state == PH_DONE);

  // R9
  missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_any) |=> missed_trig);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R8
  cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cycle_len == TIMER_W'(acq_cycle_clocks(lat_trig, lat_acq, lat_int,
                                    lat_dig, lat_cnt, lat_per, ACQ_DIV))));
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_int) && $stable(lat_cnt) &&
                               $stable(lat_per) && $stable(lat_trig)));
  // R6
  ramp_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en) |-> (ramp_step && $past(sh_hold)));
endmodule

// File: tb/tb_acq_timing_seq.sv
module tb_acq_timing_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_run = 1'b0, trig_evt = 1'b0;
  logic [15:0] cfg_trig_dly = '0;
  logic [9:0]  cfg_acq_dly = '0;
  logic [15:0] cfg_int_time = '0;
  logic [11:0] cfg_dig_dly = '0;
  logic [13:0] cfg_step_cnt = '0;
  logic [7:0]  cfg_step_per = '0;
  logic        amp_rst_release, sh_hold, ramp_step, cnt_en, busy, done, missed_trig;
  logic [31:0] cycle_len;

  always #2 clk = ~clk;

  acq_timing_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_run(trig_run), .trig_evt(trig_evt),
    .cfg_trig_dly(cfg_trig_dly), .cfg_acq_dly(cfg_acq_dly),
    .cfg_int_time(cfg_int_time), .cfg_dig_dly(cfg_dig_dly),
    .cfg_step_cnt(cfg_step_cnt), .cfg_step_per(cfg_step_per),
    .amp_rst_release(amp_rst_release), .sh_hold(sh_hold), .ramp_step(ramp_step),
    .cnt_en(cnt_en), .busy(busy), .done(done), .missed_trig(missed_trig),
    .cycle_len(cycle_len));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic mon_clr = 1'b0;
  longint m_pre, m_int, m_set, m_ramp, m_step, m_done, m_busy;
  bit m_seen_int, m_ramp_seen, m_first_step;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Phase lengths restated from the requirements.
  function automatic longint pre_len(input longint t, input longint a);
    return t + 1 + 128 * (a + 1);
  endfunction
  function automatic longint total_len(input longint t, input longint a, input longint i,
                                       input longint d, input longint c, input longint p);
    longint s;
    s = pre_len(t, a);
    s += i + 1;
    s += d + 1;
    s += (c + 1) * (p + 1);
    return s + 1;
  endfunction

  always @(negedge clk) begin
    if (mon_clr) begin
      m_pre = 0; m_int = 0; m_set = 0; m_ramp = 0; m_step = 0; m_done = 0; m_busy = 0;
      m_seen_int = 0; m_ramp_seen = 0; m_first_step = 0;
    end else begin
      if (busy) m_busy++;
      if (amp_rst_release) begin m_int++; m_seen_int = 1; end
      else if (busy && !m_seen_int) m_pre++;
      if (sh_hold && !cnt_en) m_set++;
      if (cnt_en) begin
        if (!m_ramp_seen) begin m_ramp_seen = 1; m_first_step = ramp_step; end
        m_ramp++;
      end
      if (ramp_step) m_step++;
      if (done) m_done++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_cycle(input int t, input int a, input int i, input int d,
                           input int c, input int p, input bit evt, input bit disturb,
                           input string tag);
    @(posedge clk); #1;
    cfg_trig_dly = 16'(t); cfg_acq_dly = 10'(a); cfg_int_time = 16'(i);
    cfg_dig_dly = 12'(d); cfg_step_cnt = 14'(c); cfg_step_per = 8'(p);
    trig_evt = evt; trig_run = !evt; mon_clr = 1'b1;
    @(posedge clk); #1;
    trig_evt = 1'b0; trig_run = 1'b0; mon_clr = 1'b0;
    if (disturb) begin
      // R9 / R10: retrigger and reprogram while busy
      repeat (3) @(posedge clk);
      #1;
      trig_run = 1'b1; trig_evt = 1'b1;
      cfg_trig_dly = 16'(t + 7); cfg_acq_dly = 10'(a + 1); cfg_int_time = 16'(i + 9);
      cfg_dig_dly = 12'(d + 5); cfg_step_cnt = 14'(c + 3); cfg_step_per = 8'(p + 2);
      @(posedge clk); #1;
      trig_run = 1'b0; trig_evt = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk); #1;
    check({tag, " R2 R3 pre-window"}, m_pre, pre_len(t, a));
    check({tag, " R4 window"}, m_int, i + 1);
    check({tag, " R5 settle"}, m_set, d + 1);
    check({tag, " R6 ramp length"}, m_ramp, longint'(c + 1) * (p + 1));
    check({tag, " R6 step pulses"}, m_step, c + 1);
    check({tag, " R6 first step"}, m_first_step, 1);
    check({tag, " R7 done once"}, m_done, 1);
    check({tag, " R7 idle after"}, busy, 0);
    check({tag, " R8 cycle_len"}, cycle_len, total_len(t, a, i, d, c, p));
    check({tag, " R8 busy count"}, m_busy, total_len(t, a, i, d, c, p));
    check({tag, " R9 missed flag"}, missed_trig, disturb);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 reset strobes", {amp_rst_release, sh_hold, ramp_step, cnt_en}, 0);
    check("R1 reset status", {busy, done, missed_trig}, 0);
    check("R1 reset cycle_len", cycle_len, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset idle", busy, 0);

    run_cycle(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "zeros");
    run_cycle(3, 2, 10, 4, 5, 2, 1'b1, 1'b0, "evt");
    run_cycle(5, 0, 20, 2, 6, 1, 1'b0, 1'b1, "disturb R10");
    run_cycle(1, 1, 2, 1, 2, 0, 1'b1, 1'b0, "clear R9");
    for (int k = 0; k < 16; k++) begin
      run_cycle(int'($urandom_range(0, 20)), int'($urandom_range(0, 2)),
                int'($urandom_range(0, 50)), int'($urandom_range(0, 20)),
                int'($urandom_range(0, 40)), int'($urandom_range(0, 5)),
                k[0], (k % 4) == 3, "random");
    end
    // R11: full 14-bit step count
    run_cycle(2, 0, 4, 3, 16383, 0, 1'b0, 1'b0, "R11 max steps");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule